// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block is the architectural register store for a 32-bit RISC core with seven operating modes. It keeps 31 physical general registers, one current status word and five saved status words. The 16 register indices an instruction can name resolve to different physical entries depending on the mode held in the status word. Banking is done inside the block. Decode and pipeline logic only present a 4-bit index and read or write data.

Two read ports are combinational and one write port is clocked. All three are addressed by the architectural index. The current status word has its own write port and is always visible on an output. The saved status word of the current mode has a separate read/write port. An exception-entry strobe, together with a target mode code, copies the current status word into the saved status word of that target mode. Index 15 is the program counter. It is stored here like any other register and is changed only through the normal write port.

Top module: `banked_regfile`

## Requirements
- R1: While reset is asserted, the current status word becomes 0x000000D3 (mode Supervisor, I and F set). Every general register and every saved status word becomes zero.
- R2: Indices 0 to 7 and 15 map to one shared physical entry each, in every mode.
- R3: Indices 8 to 12 have a private set in FIQ mode (code 10001). Every other mode shares the User set.
- R4: Indices 13 and 14 have private copies in FIQ, IRQ (10010), Supervisor (10011), Abort (10111) and Undefined (11011). System (11111) uses the User (10000) copies. Any other mode code is treated as User.
- R5: Both read ports return the addressed entry combinationally. A write lands at the rising edge. A read of the entry being written in the same cycle returns the old value.
- R6: The status fields are N[31], Z[30], C[29], V[28], Q[27], J[24], I[7], F[6], T[5] and mode[4:0]. A write to the current or saved status word stores only these bits. All other bits read as zero.
- R7: The saved-status port addresses the current mode's saved word. In User, System or an unknown mode it reads zero, and a write changes nothing.
- R8: When exc_enter is high at a rising edge, the current status word (its value before that edge) is copied into the saved word of exc_mode. If exc_mode has no saved word, nothing changes. The strobe takes precedence over a saved-status write in the same cycle.
- R9: Register banking follows the mode field of the stored current status word, so a mode change written at an edge affects index mapping from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| rd_a_idx | input | 4 | Read port A index |
| rd_a_data | output | 32 | Read port A data |
| rd_b_idx | input | 4 | Read port B index |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | General register write enable |
| wr_idx | input | 4 | Write index |
| wr_data | input | 32 | Write data |
| psr_we | input | 1 | Current status word write enable |
| psr_wdata | input | 32 | Current status word write data |
| psr_cur | output | 32 | Current status word |
| saved_we | input | 1 | Saved status word write enable (current mode) |
| saved_wdata | input | 32 | Saved status word write data |
| saved_rdata | output | 32 | Saved status word of the current mode, or zero |
| exc_enter | input | 1 | Exception-entry strobe |
| exc_mode | input | 5 | Target mode code for exception entry |

## Verification
Some properties are checked by assertions on every cycle. These are the reset value of the status word, the masking of status writes, a held status word when no write occurs, zero saved-status reads in User and System modes, write-then-read visibility on port A, and the copy made by exception entry into the current mode. The bench scenarios cover what depends on a history of writes across modes. That includes keeping each mode's stack and link copies apart, sharing the low registers and the program counter, System aliasing User, and unknown codes falling back to User. The scenarios also cover the one-cycle lag of banking after a mode change and the precedence of exception entry over a saved-status write.

// File: rtl/banked_regfile.sv
module banked_regfile #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    rd_a_idx,
  output logic [DW-1:0] rd_a_data,
  input  logic [3:0]    rd_b_idx,
  output logic [DW-1:0] rd_b_data,
  input  logic          wr_en,
  input  logic [3:0]    wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic          psr_we,
  input  logic [DW-1:0] psr_wdata,
  output logic [DW-1:0] psr_cur,
  input  logic          saved_we,
  input  logic [DW-1:0] saved_wdata,
  output logic [DW-1:0] saved_rdata,
  input  logic          exc_enter,
  input  logic [4:0]    exc_mode
);
  localparam int NPHYS = 31;
  localparam int NBANK = 6;
  localparam logic [DW-1:0] PSR_MASK  = DW'(32'hF900_00FF);
  localparam logic [DW-1:0] PSR_RESET = DW'(32'h0000_00D3);

  // bank codes: 0 user/system, 1 fiq, 2 irq, 3 svc, 4 abort, 5 undef
  function automatic logic [2:0] bank_of(input logic [4:0] m);
    case (m)
      5'b10001: bank_of = 3'd1;
      5'b10010: bank_of = 3'd2;
      5'b10011: bank_of = 3'd3;
      5'b10111: bank_of = 3'd4;
      5'b11011: bank_of = 3'd5;
      default:  bank_of = 3'd0;
    endcase
  endfunction

  function automatic logic [4:0] phys(input logic [3:0] idx, input logic [2:0] bank);
    if ((idx == 4'd13 || idx == 4'd14) && bank != 3'd0)
      phys = 5'd19 + {1'b0, bank, 1'b0} + {4'b0, idx == 4'd14};
    else if (idx >= 4'd8 && idx <= 4'd12 && bank == 3'd1)
      phys = 5'd16 + {2'b0, idx[2:0]};
    else
      phys = {1'b0, idx};
  endfunction

  logic [DW-1:0] gpr  [NPHYS];
  logic [DW-1:0] spsr [NBANK];
  logic [DW-1:0] cpsr;
  logic [2:0]    cur_bank, tgt_bank;

  assign cur_bank = bank_of(cpsr[4:0]);
  assign tgt_bank = bank_of(exc_mode);

  assign rd_a_data   = gpr[phys(rd_a_idx, cur_bank)];
  assign rd_b_data   = gpr[phys(rd_b_idx, cur_bank)];
  assign psr_cur     = cpsr;
  assign saved_rdata = spsr[cur_bank];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NPHYS; i++) gpr[i] <= '0;
    end else if (wr_en) begin
      gpr[phys(wr_idx, cur_bank)] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cpsr <= PSR_RESET;
    else if (psr_we) cpsr <= psr_wdata & PSR_MASK;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < NBANK; b++) spsr[b] <= '0;
    end else if (exc_enter) begin
      if (tgt_bank != 3'd0) spsr[tgt_bank] <= cpsr;
    end else if (saved_we && cur_bank != 3'd0) begin
      spsr[cur_bank] <= saved_wdata & PSR_MASK;
    end
  end
endmodule

// File: rtl/banked_regfile_chk.sv
module banked_regfile_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [3:0]  rd_a_idx,
  input logic [31:0] rd_a_data,
  input logic        wr_en,
  input logic [3:0]  wr_idx,
  input logic [31:0] wr_data,
  input logic        psr_we,
  input logic [31:0] psr_wdata,
  input logic [31:0] psr_cur,
  input logic [31:0] saved_rdata,
  input logic        exc_enter,
  input logic [4:0]  exc_mode
);
  logic unpriv, exc_self;
  assign unpriv = !(psr_cur[4:0] inside {5'b10001, 5'b10010, 5'b10011, 5'b10111, 5'b11011});
  assign exc_self = exc_enter && !psr_we && !unpriv && exc_mode == psr_cur[4:0];

  p_reset_psr_r1: assert property (@(posedge clk) !rst_n |=> psr_cur == 32'h0000_00D3);

  p_wr_visible_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !psr_we) ##1 (rd_a_idx == $past(wr_idx)) |-> rd_a_data == $past(wr_data));

  p_psr_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    psr_we |=> psr_cur == ($past(psr_wdata) & 32'hF900_00FF));

  p_psr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !psr_we |=> $stable(psr_cur));

  p_unpriv_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    unpriv |-> saved_rdata == 32'h0);

  p_exc_copy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    exc_self |=> saved_rdata == $past(psr_cur));
endmodule

bind banked_regfile banked_regfile_chk chk_i (.*);

// File: tb/banked_regfile_tb_top.sv
module banked_regfile_tb_top;
  logic        clk = 0, rst_n = 0;
  logic [3:0]  rd_a_idx = 0, rd_b_idx = 0, wr_idx = 0;
  logic [31:0] rd_a_data, rd_b_data, wr_data = 0, psr_wdata = 0, psr_cur;
  logic [31:0] saved_wdata = 0, saved_rdata;
  logic        wr_en = 0, psr_we = 0, saved_we = 0, exc_enter = 0;
  logic [4:0]  exc_mode = 0;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  banked_regfile dut_i (.*);

  localparam logic [4:0] MU = 5'h10, MF = 5'h11, MI = 5'h12, MS = 5'h13,
                         MA = 5'h17, MD = 5'h1B, MY = 5'h1F;
  // {is_read, mode, index, data-or-expected}
  localparam int NV = 24;
  localparam logic [41:0] VEC [NV] = '{
    {1'b0, MU, 4'd13, 32'h1111_0013}, {1'b0, MF, 4'd13, 32'hF000_0013},
    {1'b0, MI, 4'd13, 32'h1200_0013}, {1'b0, MS, 4'd13, 32'h5300_0013},
    {1'b0, MA, 4'd13, 32'hAB00_0013}, {1'b0, MD, 4'd13, 32'h0D00_0013},
    {1'b0, MU, 4'd8,  32'h0000_0808}, {1'b0, MF, 4'd8,  32'hF000_0808},
    {1'b0, MY, 4'd14, 32'h5E00_000E}, {1'b0, MI, 4'd0,  32'h0000_00A0},
    {1'b0, MS, 4'd15, 32'h0000_1000}, {1'b0, MF, 4'd12, 32'hF000_0C0C},
    {1'b1, MY, 4'd13, 32'h1111_0013}, {1'b1, MF, 4'd13, 32'hF000_0013},
    {1'b1, MI, 4'd13, 32'h1200_0013}, {1'b1, MS, 4'd13, 32'h5300_0013},
    {1'b1, MA, 4'd13, 32'hAB00_0013}, {1'b1, MD, 4'd13, 32'h0D00_0013},
    {1'b1, MI, 4'd8,  32'h0000_0808}, {1'b1, MF, 4'd8,  32'hF000_0808},
    {1'b1, MU, 4'd14, 32'h5E00_000E}, {1'b1, MF, 4'd0,  32'h0000_00A0},
    {1'b1, 5'h15, 4'd13, 32'h1111_0013}, {1'b1, MA, 4'd15, 32'h0000_1000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic set_psr(input logic [31:0] v);
    @(negedge clk); psr_we = 1; psr_wdata = v;
    @(negedge clk); psr_we = 0;
  endtask

  task automatic set_mode(input logic [4:0] m);
    set_psr({24'h0, 3'b110, m});
  endtask

  task automatic write_reg(input logic [3:0] i, input logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_idx = i; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic write_saved(input logic [31:0] d);
    @(negedge clk); saved_we = 1; saved_wdata = d;
    @(negedge clk); saved_we = 0;
  endtask

  function automatic string tag_of(input logic [3:0] i);
    if (i < 4'd8 || i == 4'd15) return "R2";
    if (i <= 4'd12) return "R3";
    return "R4";
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1 reset state
    check("R1 psr", psr_cur, 32'h0000_00D3);
    check("R1 saved", saved_rdata, 32'h0);
    rd_a_idx = 4'd13; rd_b_idx = 4'd15; #1;
    check("R1 r13", rd_a_data, 32'h0);
    check("R1 r15", rd_b_data, 32'h0);

    // table of banked writes then reads (R2 R3 R4)
    for (int i = 0; i < NV; i++) begin
      logic [41:0] v;
      v = VEC[i];
      set_mode(v[40:36]);
      if (v[41]) begin
        rd_a_idx = v[35:32]; rd_b_idx = v[35:32]; #1;
        check(tag_of(v[35:32]), rd_a_data, v[31:0]);
        check("R5 port b", rd_b_data, v[31:0]);
      end else begin
        write_reg(v[35:32], v[31:0]);
      end
    end

    // R5: dual ports on different entries, read during write
    set_mode(MF);
    rd_a_idx = 4'd13; rd_b_idx = 4'd0; #1;
    check("R5 a", rd_a_data, 32'hF000_0013);
    check("R5 b", rd_b_data, 32'h0000_00A0);
    @(negedge clk); wr_en = 1; wr_idx = 4'd3; wr_data = 32'hAAAA_5555; rd_a_idx = 4'd3; #1;
    check("R5 old value", rd_a_data, 32'h0);
    @(posedge clk); #1;
    check("R5 new value", rd_a_data, 32'hAAAA_5555);
    @(negedge clk); wr_en = 0;

    // R9: banking lags a status write by one edge
    set_mode(MS);
    @(negedge clk); psr_we = 1; psr_wdata = {24'h0, 3'b110, MF}; rd_a_idx = 4'd13; #1;
    check("R9 before edge", rd_a_data, 32'h5300_0013);
    @(posedge clk); #1;
    check("R9 after edge", rd_a_data, 32'hF000_0013);
    @(negedge clk); psr_we = 0;

    // R6 masking
    set_psr(32'hFFFF_FFFF); #1;
    check("R6 psr mask", psr_cur, 32'hF900_00FF);

    // R7 saved status per mode
    set_mode(MS);
    write_saved(32'hFFFF_FFFF); #1;
    check("R6 saved mask", saved_rdata, 32'hF900_00FF);
    write_saved(32'h2000_0013); #1;
    check("R7 svc saved", saved_rdata, 32'h2000_0013);
    set_mode(MU);
    write_saved(32'h1234_5678); #1;
    check("R7 user reads zero", saved_rdata, 32'h0);
    set_mode(MY);
    write_saved(32'h8765_4321); #1;
    check("R7 system reads zero", saved_rdata, 32'h0);
    set_mode(MS); #1;
    check("R7 svc untouched", saved_rdata, 32'h2000_0013);
    set_mode(MA); #1;
    check("R7 abort untouched", saved_rdata, 32'h0);

    // R8 exception entry
    set_psr(32'h8000_00D0);
    @(negedge clk); exc_enter = 1; exc_mode = MI;
    @(negedge clk); exc_enter = 0;
    set_mode(MI); #1;
    check("R8 copy to irq", saved_rdata, 32'h8000_00D0);
    @(negedge clk); exc_enter = 1; exc_mode = MU;
    @(negedge clk); exc_mode = 5'h00;
    @(negedge clk); exc_enter = 0; #1;
    check("R8 no-saved targets ignored", saved_rdata, 32'h8000_00D0);
    @(negedge clk); exc_enter = 1; exc_mode = MI; saved_we = 1; saved_wdata = 32'h0000_0055;
    @(negedge clk); exc_enter = 0; saved_we = 0; #1;
    check("R8 precedence", saved_rdata, 32'h0000_00D2);
    set_mode(MS); #1;
    check("R8 other bank intact", saved_rdata, 32'h2000_0013);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule